// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a bus-attached peripheral with three 8-bit parallel ports (A, B and C) and a control register that can only be written. A host reaches it through an active-low chip select, active-low read and write strobes, a 2-bit address and an 8-bit data bus. The control register accepts two kinds of word. A mode word sets the direction and operating mode of every port. A set/reset word forces one port C line high or low.

Ports A and B each run in one of two modes. In basic mode the port is a plain latched output or a direct pin input. In strobed mode the port moves data under a single handshake. That handshake uses strobe, buffer-flag and interrupt lines, all taken from port C. Port C lines that no handshake claims work as two independent 4-bit ports, each with its own direction. Every port sits on one synchronous clock. Pads are shown as separate input, output and output-enable signals.

Top module: `pio_port_ctrl`

## Requirements
- R1: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register. A write takes effect on the first rising clock edge at which `cs_ni` and `wr_ni` are both low, and only once per strobe. While `cs_ni` and `rd_ni` are both low, `data_o` shows the selected read value; otherwise it is 0. Reading address 11 returns 0.
- R2: While `cs_ni` is high, read and write strobes have no effect on any register or output.
- R3: After reset every port is an input: all output enables are 0, every output latch is 0 and `data_o` is 0.
- R4: A control word with bit 7 = 1 is a mode word. Bits 6:5 = 01 put port A in strobed mode; any other value gives basic mode. Bit 4 = 1 makes port A an input. Bit 3 = 1 makes the upper port C nibble an input. Bit 2 = 1 puts port B in strobed mode. Bit 1 = 1 makes port B an input. Bit 0 = 1 makes the lower port C nibble an input. Any mode word clears all three output latches and all handshake flags.
- R5: In basic mode an output port drives its latch with its output enable set, and a read returns the latch. An input port has its enable cleared, and a read returns the live pin value.
- R6: The two port C nibbles follow their own direction bits. On a port C read, each output bit returns its latch value and each input bit returns its pin.
- R7: A control word with bit 7 = 0 writes bit 0 into the port C latch bit chosen by bits 3:1. The other latch bits do not change.
- R8: Port B strobed input uses these lines: PC2 is the active-low strobe, PC1 is buffer-full and PC0 is the interrupt. A low strobe captures `pb_i` and sets buffer-full. The strobe's return high sets the interrupt when latch bit PC2 is 1. The falling edge of a port B read clears the interrupt, and the end of that read clears buffer-full. Reads return the captured byte.
- R9: Port B strobed output uses PC2 as the active-low acknowledge, PC1 as the active-low output-full line and PC0 as the interrupt. A port B write pulls PC1 low and clears the interrupt. A low acknowledge returns PC1 high. The acknowledge's return high sets the interrupt when latch bit PC2 is 1.
- R10: Port A strobed input uses PC4 as the strobe, PC5 as buffer-full and PC3 as the interrupt, with latch bit PC4 as the interrupt enable. It follows the same rules as R8, applied to port A. PC6 and PC7 follow the upper nibble direction.
- R11: Port A strobed output uses PC6 as the acknowledge, PC7 as the active-low output-full line and PC3 as the interrupt, with latch bit PC6 as the interrupt enable. It follows the same rules as R9, applied to port A. PC4 and PC5 follow the upper nibble direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register select |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, 0 when not reading |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 1 | Port A output enable |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 1 | Port B output enable |
| pc_i | input | 8 | Port C pin inputs, including strobe and acknowledge lines |
| pc_o | output | 8 | Port C drive values, including handshake status lines |
| pc_oe_o | output | 8 | Port C per-bit output enable |

## Verification
Random mode words in basic mode cover every mix of port and nibble directions. They are combined with random latch writes, random set/reset words, writes issued with chip select high, and random pin values. This separates the cases where a read must return the latch from those where it must return the pin, and shows whether a deselected write is dropped. Port A mode values 10 and 11 appear in the mix, which shows whether they fall back to basic mode. Directed sequences then drive each handshake through strobe low, strobe high, read start and read end. This confirms that buffer-full and the interrupt change at the right edges, that a disabled interrupt stays low, and that a later mode word clears the latches.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PW   = 8;
  localparam int unsigned HALF = PW / 2;
  localparam int unsigned CIW  = $clog2(PW);
  localparam int unsigned NHS  = 2;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  typedef struct packed {
    logic a_strb;
    logic a_in;
    logic ch_in;
    logic b_strb;
    logic b_in;
    logic cl_in;
  } mode_t;

  localparam mode_t MODE_RST = '{a_strb: 1'b0, a_in: 1'b1, ch_in: 1'b1,
                                 b_strb: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pio_bus.sv
module pio_bus
  import pio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [PW-1:0] data_i,
  output mode_t         mode_o,
  output logic          mode_wr_o,
  output logic [2:0]    wr_sel_o,
  output logic [NHS-1:0] rd_fall_o,
  output logic [NHS-1:0] rd_rise_o,
  output logic [PW-1:0] pa_q_o,
  output logic [PW-1:0] pb_q_o,
  output logic [PW-1:0] pc_q_o
);
  logic       wr_act, wr_act_q, rd_act, rd_act_q, wr_ev, bsr_wr;
  logic [1:0] rd_addr_q;

  assign wr_act = !cs_ni && !wr_ni;
  assign rd_act = !cs_ni && !rd_ni;
  assign wr_ev  = wr_act && !wr_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (rd_act && !rd_act_q) rd_addr_q <= addr_i;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_wsel
    assign wr_sel_o[i] = wr_ev && (addr_i == 2'(i));
  end

  // read edges only matter for the two handshake ports
  for (genvar i = 0; i < NHS; i++) begin : g_rsel
    assign rd_fall_o[i] = rd_act && !rd_act_q && (addr_i == 2'(i));
    assign rd_rise_o[i] = !rd_act && rd_act_q && (rd_addr_q == 2'(i));
  end

  assign mode_wr_o = wr_ev && (addr_i == SEL_CTL) && data_i[7];
  assign bsr_wr    = wr_ev && (addr_i == SEL_CTL) && !data_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_RST;
      pa_q_o <= '0;
      pb_q_o <= '0;
      pc_q_o <= '0;
    end else if (mode_wr_o) begin
      mode_o <= '{a_strb: (data_i[6:5] == 2'b01), a_in: data_i[4], ch_in: data_i[3],
                  b_strb: data_i[2], b_in: data_i[1], cl_in: data_i[0]};
      pa_q_o <= '0;
      pb_q_o <= '0;
      pc_q_o <= '0;
    end else begin
      if (wr_sel_o[0]) pa_q_o <= data_i;
      if (wr_sel_o[1]) pb_q_o <= data_i;
      if (wr_sel_o[2]) pc_q_o <= data_i;
      if (bsr_wr) pc_q_o[data_i[CIW:1]] <= data_i[0];
    end
  end
endmodule

// File: rtl/pio_hs.sv
module pio_hs
  import pio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dir_in_i,
  input  logic          hs_ni,
  input  logic          inte_i,
  input  logic [PW-1:0] pin_i,
  input  logic          port_wr_i,
  input  logic          rd_fall_i,
  input  logic          rd_rise_i,
  input  logic          clr_i,
  output logic [PW-1:0] in_q_o,
  output logic          buf_o,
  output logic          intr_o
);
  logic hs_q, hs_rise;

  assign hs_rise = en_i && hs_ni && !hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b1;
      in_q_o <= '0;
      buf_o  <= 1'b0;
      intr_o <= 1'b0;
    end else begin
      hs_q <= hs_ni;
      if (clr_i || !en_i) begin
        in_q_o <= '0;
        buf_o  <= 1'b0;
        intr_o <= 1'b0;
      end else if (dir_in_i) begin
        // buf_o is input-buffer-full
        if (!hs_ni) begin
          in_q_o <= pin_i;
          buf_o  <= 1'b1;
        end else if (rd_rise_i) begin
          buf_o <= 1'b0;
        end
        if (hs_rise && inte_i && buf_o) intr_o <= 1'b1;
        if (rd_fall_i) intr_o <= 1'b0;
      end else begin
        // buf_o is output-full; a write wins over a same-cycle ack
        if (!hs_ni) buf_o <= 1'b0;
        if (port_wr_i) buf_o <= 1'b1;
        if (hs_rise && inte_i) intr_o <= 1'b1;
        if (port_wr_i) intr_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [PW-1:0] data_i,
  output logic [PW-1:0] data_o,
  input  logic [PW-1:0] pa_i,
  output logic [PW-1:0] pa_o,
  output logic          pa_oe_o,
  input  logic [PW-1:0] pb_i,
  output logic [PW-1:0] pb_o,
  output logic          pb_oe_o,
  input  logic [PW-1:0] pc_i,
  output logic [PW-1:0] pc_o,
  output logic [PW-1:0] pc_oe_o
);
  mode_t          mode;
  logic           mode_wr;
  logic [2:0]     wr_sel;
  logic [NHS-1:0] rd_fall, rd_rise;
  logic [PW-1:0]  pa_q, pb_q, pc_q, a_in_q, b_in_q;
  logic [PW-1:0]  pa_rd, pb_rd, pc_rd;
  logic           a_buf, a_intr, b_buf, b_intr, a_hs_n, a_inte;

  pio_bus u_bus (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .mode_o(mode), .mode_wr_o(mode_wr), .wr_sel_o(wr_sel),
    .rd_fall_o(rd_fall), .rd_rise_o(rd_rise),
    .pa_q_o(pa_q), .pb_q_o(pb_q), .pc_q_o(pc_q)
  );

  // port A handshake line and enable move with direction
  assign a_hs_n = mode.a_in ? pc_i[4] : pc_i[6];
  assign a_inte = mode.a_in ? pc_q[4] : pc_q[6];

  pio_hs u_hs_a (
    .clk_i, .rst_ni, .en_i(mode.a_strb), .dir_in_i(mode.a_in), .hs_ni(a_hs_n),
    .inte_i(a_inte), .pin_i(pa_i), .port_wr_i(wr_sel[0]), .rd_fall_i(rd_fall[0]),
    .rd_rise_i(rd_rise[0]), .clr_i(mode_wr), .in_q_o(a_in_q), .buf_o(a_buf), .intr_o(a_intr)
  );

  pio_hs u_hs_b (
    .clk_i, .rst_ni, .en_i(mode.b_strb), .dir_in_i(mode.b_in), .hs_ni(pc_i[2]),
    .inte_i(pc_q[2]), .pin_i(pb_i), .port_wr_i(wr_sel[1]), .rd_fall_i(rd_fall[1]),
    .rd_rise_i(rd_rise[1]), .clr_i(mode_wr), .in_q_o(b_in_q), .buf_o(b_buf), .intr_o(b_intr)
  );

  always_comb begin
    pc_oe_o = {{HALF{!mode.ch_in}}, {HALF{!mode.cl_in}}};
    pc_o    = pc_q;
    if (mode.b_strb) begin
      pc_oe_o[2:0] = 3'b011;
      pc_o[0]      = b_intr;
      pc_o[1]      = mode.b_in ? b_buf : !b_buf;
    end
    if (mode.a_strb) begin
      pc_oe_o[3] = 1'b1;
      pc_o[3]    = a_intr;
      if (mode.a_in) begin
        pc_oe_o[4] = 1'b0;
        pc_oe_o[5] = 1'b1;
        pc_o[5]    = a_buf;
      end else begin
        pc_oe_o[6] = 1'b0;
        pc_oe_o[7] = 1'b1;
        pc_o[7]    = !a_buf;
      end
    end
  end

  assign pa_o    = pa_q;
  assign pb_o    = pb_q;
  assign pa_oe_o = !mode.a_in;
  assign pb_oe_o = !mode.b_in;

  assign pa_rd = mode.a_in ? (mode.a_strb ? a_in_q : pa_i) : pa_q;
  assign pb_rd = mode.b_in ? (mode.b_strb ? b_in_q : pb_i) : pb_q;
  assign pc_rd = (pc_o & pc_oe_o) | (pc_i & ~pc_oe_o);

  always_comb begin
    data_o = '0;
    if (!cs_ni && !rd_ni) begin
      case (addr_i)
        SEL_A:   data_o = pa_rd;
        SEL_B:   data_o = pb_rd;
        SEL_C:   data_o = pc_rd;
        default: data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_port_ctrl_chk.sv
module pio_port_ctrl_chk
  import pio_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          rd_ni,
  input logic [1:0]    addr_i,
  input logic [PW-1:0] data_o,
  input logic [PW-1:0] pa_o,
  input logic [PW-1:0] pc_oe_o,
  input logic          obf_b_n,
  input logic          b_obf_mode,
  input logic          b_wr
);
  // R1
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> data_o == '0);

  // R1
  ctl_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && addr_i == 2'b11) |-> data_o == '0);

  // R2
  desel_latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(pa_o));

  // R2
  desel_dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(pc_oe_o));

  // R9
  obf_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_wr && b_obf_mode) |=> !obf_b_n);
endmodule

bind pio_port_ctrl pio_port_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .addr_i(addr_i),
  .data_o(data_o), .pa_o(pa_o), .pc_oe_o(pc_oe_o), .obf_b_n(pc_o[1]),
  .b_obf_mode(mode.b_strb && !mode.b_in), .b_wr(wr_sel[1])
);

// File: tb/sim_pio_port_ctrl.sv
`timescale 1ns/1ps
module sim_pio_port_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe;
  int         n_chk = 0, n_err = 0;

  // basic-mode reference state
  logic       m_a_in, m_b_in, m_ch, m_cl;
  logic [7:0] pa_m, pb_m, pc_m;

  always #2 clk = ~clk;

  pio_port_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout),
    .pa_i(pa_in), .pa_o(pa_out), .pa_oe_o(pa_oe),
    .pb_i(pb_in), .pb_o(pb_out), .pb_oe_o(pb_oe),
    .pc_i(pc_in), .pc_o(pc_out), .pc_oe_o(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs_n = !sel; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_oe();
    return {{4{!m_ch}}, {4{!m_cl}}};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'b00:   return m_a_in ? pa_in : pa_m;
      2'b01:   return m_b_in ? pb_in : pb_m;
      2'b10:   return (pc_m & exp_oe()) | (pc_in & ~exp_oe());
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk("R3 oe", {pa_oe, pb_oe, 6'b0}, 8'h00);
    chk("R3 pc_oe", pc_oe, 8'h00);
    chk("R3 pa_o", pa_out, 8'h00);
    chk("R3 data_o", dout, 8'h00);
    pa_in = 8'h6B;
    bus_rd(2'b00, d);
    chk("R3 input read", d, 8'h6B);

    // R4 R5 R6 R7 R2 random basic-mode traffic
    for (int it = 0; it < 60; it++) begin
      logic [7:0] mw, v;
      logic       sel;
      logic [2:0] idx;
      mw = 8'h80 | (8'($urandom) & 8'h1B);
      if (it % 4 == 3) mw = mw | 8'h40 | ((it % 8 == 7) ? 8'h20 : 8'h00);
      bus_wr(2'b11, mw);
      m_a_in = mw[4]; m_ch = mw[3]; m_b_in = mw[1]; m_cl = mw[0];
      pa_m = '0; pb_m = '0; pc_m = '0;
      chk("R4 pa_oe", {7'b0, pa_oe}, {7'b0, !m_a_in});
      chk("R4 pb_oe", {7'b0, pb_oe}, {7'b0, !m_b_in});
      chk("R6 pc_oe", pc_oe, exp_oe());
      chk("R4 clear", pa_out, 8'h00);
      for (int k = 0; k < 3; k++) begin
        v = 8'($urandom); sel = ($urandom % 5) != 0;
        bus_wr(2'(k), v, sel);
        if (sel) begin
          if (k == 0) pa_m = v; else if (k == 1) pb_m = v; else pc_m = v;
        end
      end
      idx = 3'($urandom); v = {7'b0, 1'($urandom)};
      bus_wr(2'b11, {4'b0000, idx, v[0]});
      pc_m[idx] = v[0];
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      #1;
      chk("R5 R2 pa_o", pa_out, pa_m);
      chk("R5 R2 pb_o", pb_out, pb_m);
      chk("R7 R6 pc_o", pc_out & exp_oe(), pc_m & exp_oe());
      for (int a = 0; a < 4; a++) begin
        bus_rd(2'(a), d);
        chk("R1 R5 R6 read", d, exp_rd(2'(a)));
      end
    end

    // R8 port B strobed input
    pc_in = 8'hFF;
    bus_wr(2'b11, 8'h8E);
    bus_wr(2'b11, 8'h05);
    chk("R8 pc_oe", pc_oe, 8'h0B);
    pb_in = 8'h5A;
    @(negedge clk); pc_in[2] = 1'b0;
    @(negedge clk); chk("R8 ibf set", {6'b0, pc_out[1:0]}, 8'h02);
    pc_in[2] = 1'b1; pb_in = 8'hFF;
    @(negedge clk); chk("R8 intr set", {6'b0, pc_out[1:0]}, 8'h03);
    bus_rd(2'b01, d);
    chk("R8 captured data", d, 8'h5A);
    chk("R8 intr cleared", {6'b0, pc_out[1:0]}, 8'h02);
    @(negedge clk); chk("R8 ibf cleared", {6'b0, pc_out[1:0]}, 8'h00);
    bus_wr(2'b11, 8'h04);
    @(negedge clk); pc_in[2] = 1'b0;
    @(negedge clk); pc_in[2] = 1'b1;
    @(negedge clk); chk("R8 intr disabled", {6'b0, pc_out[1:0]}, 8'h02);

    // R9 port B strobed output
    bus_wr(2'b11, 8'h8C);
    bus_wr(2'b11, 8'h05);
    chk("R9 idle", {6'b0, pc_out[1:0]}, 8'h02);
    bus_wr(2'b01, 8'h3C);
    chk("R9 data", pb_out, 8'h3C);
    chk("R9 obf low", {6'b0, pc_out[1:0]}, 8'h00);
    @(negedge clk); pc_in[2] = 1'b0;
    @(negedge clk); chk("R9 ack", {6'b0, pc_out[1:0]}, 8'h02);
    pc_in[2] = 1'b1;
    @(negedge clk); chk("R9 intr set", {6'b0, pc_out[1:0]}, 8'h03);
    bus_wr(2'b01, 8'hC3);
    chk("R9 rewrite", {6'b0, pc_out[1:0]}, 8'h00);

    // R10 port A strobed input, B basic output
    bus_wr(2'b11, 8'hB0);
    bus_wr(2'b11, 8'h09);
    chk("R10 pc_oe", pc_oe, 8'hEF);
    pa_in = 8'hA7;
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk); chk("R10 ibf set", {6'b0, pc_out[5], pc_out[3]}, 8'h02);
    pc_in[4] = 1'b1; pa_in = 8'h00;
    @(negedge clk); chk("R10 intr set", {6'b0, pc_out[5], pc_out[3]}, 8'h03);
    bus_rd(2'b00, d);
    chk("R10 captured data", d, 8'hA7);
    chk("R10 intr cleared", {6'b0, pc_out[5], pc_out[3]}, 8'h02);
    @(negedge clk); chk("R10 ibf cleared", {6'b0, pc_out[5], pc_out[3]}, 8'h00);
    bus_wr(2'b11, 8'h0F);
    chk("R7 set PC7", {7'b0, pc_out[7]}, 8'h01);

    // R11 port A strobed output
    bus_wr(2'b11, 8'hA8);
    bus_wr(2'b11, 8'h0D);
    chk("R11 pc_oe", pc_oe, 8'h8F);
    bus_wr(2'b00, 8'h99);
    chk("R11 data", pa_out, 8'h99);
    chk("R11 obf low", {6'b0, pc_out[7], pc_out[3]}, 8'h00);
    @(negedge clk); pc_in[6] = 1'b0;
    @(negedge clk); chk("R11 ack", {6'b0, pc_out[7], pc_out[3]}, 8'h02);
    pc_in[6] = 1'b1;
    @(negedge clk); chk("R11 intr set", {6'b0, pc_out[7], pc_out[3]}, 8'h03);

    // R4 mode word clears latches
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h55);
    bus_wr(2'b10, 8'hF0);
    chk("R4 before clear", pa_out, 8'h55);
    bus_wr(2'b11, 8'h80);
    chk("R4 pa cleared", pa_out, 8'h00);
    chk("R4 pc cleared", pc_out, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule